// File: doc/BRIEF.md
# Reference-Clock Supervisor for a Monitored Clock

This block watches a monitored clock from the domain of a free-running reference clock. It turns every rising edge of the monitored clock into a one-cycle pulse in the reference domain. It then measures the number of reference cycles between consecutive pulses. A period below a lower limit or above an upper limit is an anomaly. So is a gap with no edge that runs longer than the upper limit plus a fixed margin, which indicates a lost clock.

Software arms the block through a small register port. A control word holds the enable, the anomaly action and the startup hold-off. A second word holds the two period limits. After the enable is set, and again each time the block leaves the low-power state, it waits a programmed number of reference cycles before it judges the monitored clock. This gives the monitored clock time to start. A detected anomaly stays latched, and it drives either a fault report or a reset request, chosen by the action bit.

While `sleep_i` is high, all supervision state is cleared. When `sleep_i` falls with the enable still set, supervision starts again on its own through a new hold-off period.

Top module: `clk_sup_mon`

## Requirements
- R1: The control word at address 0 holds the startup value in bits 15:0, the action select in bit 30 and the enable in bit 31. Bits 29:16 always read as 0. The limit word at address 1 holds the lower limit in bits 15:0 and the upper limit in bits 31:16. Both words reset to 0.
- R2: After the enable is set, no anomaly is flagged for startup+1 reference cycles. Period checking starts only after that.
- R3: When `sleep_i` falls with the enable still set, a new startup hold-off runs and supervision then resumes, with no register write needed.
- R4: When an anomaly is latched, `fault_o` is high if the action select is 0 and `rst_req_o` is high if it is 1. The two outputs are never high together.
- R5: A measured period, counted in reference cycles between monitored rising edges, that is below the lower limit latches an anomaly.
- R6: A measured period above the upper limit latches an anomaly. Any anomaly stays latched while the block remains enabled and awake, even if the clock later returns to the window.
- R7: If no monitored edge arrives for more than upper+LOSS_MARGIN reference cycles (LOSS_MARGIN = 4 by default), an anomaly is latched. A stopped clock is flagged in this way.
- R8: A monitored clock whose period lies within [lower, upper] never raises either output.
- R9: Clearing the enable clears the counters and the latched anomaly. Both outputs are low by the next reference edge.
- R10: While `sleep_i` is high, supervision state is cleared and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_mon_i | input | 1 | Monitored clock, sampled in the reference domain |
| sleep_i | input | 1 | High while the system is in the low-power state |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 1 | Register select: 0 control, 1 limits |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Read data of the selected register |
| fault_o | output | 1 | Anomaly reported as a fault |
| rst_req_o | output | 1 | Anomaly reported as a reset request |

## Verification
A corrupted hold-off counter shows at the ports as a flag that comes too early during startup, before the clock is judged, or one that never comes for a stopped clock. Both are seen within one startup period plus the loss window. A bad period counter or bad limit compare shows as a false flag on an in-window clock, or as a missing flag on a fast or slow one, within two or three monitored periods. A latch that is not cleared shows on the first reference edge after disable or sleep, when an output stays high.

// File: rtl/csm_pkg.sv
package csm_pkg;
  localparam int CSM_DW    = 32;
  localparam int CSM_LIM_W = 16;
  localparam int CSM_EN_B  = 31;
  localparam int CSM_ACT_B = 30;

  typedef enum logic [1:0] {
    CSM_IDLE = 2'd0,
    CSM_HOLD = 2'd1,
    CSM_RUN  = 2'd2
  } csm_state_e;
endpackage

// File: rtl/csm_regs.sv
module csm_regs
  import csm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we_i,
  input  logic                 addr_i,
  input  logic [CSM_DW-1:0]    wdata_i,
  output logic [CSM_DW-1:0]    rdata_o,
  output logic                 enable_o,
  output logic                 action_o,
  output logic [CSM_LIM_W-1:0] startup_o,
  output logic [CSM_LIM_W-1:0] lower_o,
  output logic [CSM_LIM_W-1:0] upper_o
);
  logic                 en_q, en_n, act_q, act_n;
  logic [CSM_LIM_W-1:0] su_q, su_n, lo_q, lo_n, hi_q, hi_n;

  always_comb begin
    en_n = en_q; act_n = act_q; su_n = su_q; lo_n = lo_q; hi_n = hi_q;
    if (we_i) begin
      if (!addr_i) begin
        en_n  = wdata_i[CSM_EN_B];
        act_n = wdata_i[CSM_ACT_B];
        su_n  = wdata_i[CSM_LIM_W-1:0];
      end else begin
        lo_n = wdata_i[CSM_LIM_W-1:0];
        hi_n = wdata_i[2*CSM_LIM_W-1:CSM_LIM_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; act_q <= 1'b0; su_q <= '0; lo_q <= '0; hi_q <= '0;
    end else if (we_i) begin
      en_q <= en_n; act_q <= act_n; su_q <= su_n; lo_q <= lo_n; hi_q <= hi_n;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (!addr_i) begin
      rdata_o[CSM_EN_B]        = en_q;
      rdata_o[CSM_ACT_B]       = act_q;
      rdata_o[CSM_LIM_W-1:0]   = su_q;
    end else begin
      rdata_o = {hi_q, lo_q};
    end
  end

  assign enable_o  = en_q;
  assign action_o  = act_q;
  assign startup_o = su_q;
  assign lower_o   = lo_q;
  assign upper_o   = hi_q;
endmodule

// File: rtl/csm_sync_edge.sv
module csm_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  localparam int SH_W = STAGES + 1;
  logic [SH_W-1:0] sh_q, sh_n;

  always_comb begin
    sh_n = {sh_q[SH_W-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_n;
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/csm_period_chk.sv
module csm_period_chk
  import csm_pkg::*;
#(
  parameter int CNT_W       = CSM_LIM_W,
  parameter int LOSS_MARGIN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic [CNT_W-1:0] startup_i,
  input  logic [CNT_W-1:0] lower_i,
  input  logic [CNT_W-1:0] upper_i,
  input  logic             edge_i,
  output logic             anomaly_o
);
  localparam int          WW   = CNT_W + 1;
  localparam logic [WW-1:0] MARG = WW'(LOSS_MARGIN);

  csm_state_e       state_q, state_n;
  logic [CNT_W-1:0] scnt_q, scnt_n, pcnt_q, pcnt_n;
  logic             seen_q, seen_n, anom_q, anom_n;
  logic [WW-1:0]    period, loss_thr;

  assign period   = {1'b0, pcnt_q} + WW'(1);
  assign loss_thr = {1'b0, upper_i} + MARG;

  always_comb begin
    state_n = state_q; scnt_n = scnt_q; pcnt_n = pcnt_q;
    seen_n  = seen_q;  anom_n = anom_q;
    if (!active_i) begin
      state_n = CSM_IDLE; scnt_n = '0; pcnt_n = '0; seen_n = 1'b0; anom_n = 1'b0;
    end else begin
      case (state_q)
        CSM_IDLE: begin
          pcnt_n = '0; seen_n = 1'b0;
          if (startup_i == '0) state_n = CSM_RUN;
          else begin state_n = CSM_HOLD; scnt_n = CNT_W'(1); end
        end
        CSM_HOLD: begin
          if (scnt_q >= startup_i) begin
            state_n = CSM_RUN; pcnt_n = '0; seen_n = 1'b0;
          end else scnt_n = scnt_q + CNT_W'(1);
        end
        CSM_RUN: begin
          if (edge_i) begin
            if (seen_q && ((period < {1'b0, lower_i}) || (period > {1'b0, upper_i})))
              anom_n = 1'b1;
            seen_n = 1'b1;
            pcnt_n = '0;
          end else begin
            if (period > loss_thr) anom_n = 1'b1;
            if (pcnt_q != '1) pcnt_n = pcnt_q + CNT_W'(1);
          end
        end
        default: state_n = CSM_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CSM_IDLE; scnt_q <= '0; pcnt_q <= '0; seen_q <= 1'b0; anom_q <= 1'b0;
    end else begin
      state_q <= state_n; scnt_q <= scnt_n; pcnt_q <= pcnt_n; seen_q <= seen_n; anom_q <= anom_n;
    end
  end

  assign anomaly_o = anom_q;

  // R9 / R10: leaving the active condition wipes the latch and the state
  p_clear_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> (!anom_q && state_q == CSM_IDLE));
  // R2: nothing is flagged during the hold-off
  p_hold_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CSM_HOLD) |-> !anom_q);
  // R6: an anomaly stays latched while supervision is active
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (anom_q && active_i) |=> anom_q);
endmodule

// File: rtl/clk_sup_mon.sv
module clk_sup_mon
  import csm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOSS_MARGIN = 4
) (
  input  logic              clk_ref_i,
  input  logic              rst_ni,
  input  logic              clk_mon_i,
  input  logic              sleep_i,
  input  logic              cfg_we_i,
  input  logic              cfg_addr_i,
  input  logic [CSM_DW-1:0] cfg_wdata_i,
  output logic [CSM_DW-1:0] cfg_rdata_o,
  output logic              fault_o,
  output logic              rst_req_o
);
  logic [1:0]           rsync_q;
  logic                 rst_n;
  logic                 en, act, mon_rise, anomaly, active;
  logic [CSM_LIM_W-1:0] startup, lower, upper;

  always_ff @(posedge clk_ref_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= 2'b00;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  csm_regs u_regs (
    .clk(clk_ref_i), .rst_n(rst_n), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .rdata_o(cfg_rdata_o), .enable_o(en), .action_o(act),
    .startup_o(startup), .lower_o(lower), .upper_o(upper)
  );

  csm_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk_ref_i), .rst_n(rst_n), .async_i(clk_mon_i), .rise_o(mon_rise)
  );

  assign active = en & ~sleep_i;

  csm_period_chk #(.CNT_W(CSM_LIM_W), .LOSS_MARGIN(LOSS_MARGIN)) u_chk (
    .clk(clk_ref_i), .rst_n(rst_n), .active_i(active), .startup_i(startup),
    .lower_i(lower), .upper_i(upper), .edge_i(mon_rise), .anomaly_o(anomaly)
  );

  assign fault_o   = anomaly & ~act;
  assign rst_req_o = anomaly & act;

  // R4: the two report outputs are mutually exclusive
  p_one_report_r4: assert property (@(posedge clk_ref_i) disable iff (!rst_n)
    $onehot0({fault_o, rst_req_o}));
endmodule

// File: tb/clk_sup_mon_bench.sv
module clk_sup_mon_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mon_clk = 1'b0;
  logic        sleep = 1'b0;
  logic        we = 1'b0;
  logic        addr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        fault, rreq;
  int          checks = 0;
  int          errors = 0;
  int          mon_half = 0;
  int          hc = 0;

  clk_sup_mon u_clk_sup_mon (
    .clk_ref_i(clk), .rst_ni(rst_n), .clk_mon_i(mon_clk), .sleep_i(sleep),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata),
    .fault_o(fault), .rst_req_o(rreq)
  );

  always #5 clk = ~clk;

  // monitored clock: period = 2*mon_half reference cycles, 0 = stopped
  always @(negedge clk) begin
    if (mon_half != 0) begin
      if (hc >= mon_half - 1) begin mon_clk <= ~mon_clk; hc <= 0; end
      else hc <= hc + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic arm(input logic act, input logic [15:0] su, input logic [15:0] lo,
                     input logic [15:0] hi);
    wr(1'b0, 32'h0);
    wr(1'b1, {hi, lo});
    wr(1'b0, {1'b1, act, 14'h0, su});
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 reset fault", {31'b0, fault}, 32'h0);
    check("R1 reset rst_req", {31'b0, rreq}, 32'h0);
    rd(1'b0, d); check("R1 reset ctl", d, 32'h0);
    rd(1'b1, d); check("R1 reset limits", d, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    sleep = 1'b1;
    wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b0, d); check("R1 reserved bits read zero", d, 32'hC000_FFFF);
    wr(1'b1, 32'h1234_ABCD);
    rd(1'b1, d); check("R1 limit word", d, 32'h1234_ABCD);
    wr(1'b0, 32'h0);
    sleep = 1'b0;
  endtask

  task automatic t_window();
    mon_half = 5;
    arm(1'b0, 16'd40, 16'd8, 16'd12);
    wait_cyc(300);
    check("R8 in-window fault", {31'b0, fault}, 32'h0);
    check("R8 in-window rst_req", {31'b0, rreq}, 32'h0);
  endtask

  task automatic t_fast();
    mon_half = 2;
    arm(1'b0, 16'd40, 16'd8, 16'd12);
    wait_cyc(150);
    check("R5 fast clock fault", {31'b0, fault}, 32'h1);
    check("R4 action 0 no rst_req", {31'b0, rreq}, 32'h0);
    wr(1'b0, 32'h0);
    wait_cyc(1);
    check("R9 disable clears fault", {31'b0, fault}, 32'h0);
  endtask

  task automatic t_slow();
    mon_half = 7;
    arm(1'b1, 16'd40, 16'd8, 16'd12);
    wait_cyc(150);
    check("R6 slow clock rst_req", {31'b0, rreq}, 32'h1);
    check("R4 action 1 no fault", {31'b0, fault}, 32'h0);
    mon_half = 5;
    wait_cyc(100);
    check("R6 sticky after recovery", {31'b0, rreq}, 32'h1);
    wr(1'b0, 32'h0);
    wait_cyc(1);
    check("R9 disable clears rst_req", {31'b0, rreq}, 32'h0);
  endtask

  task automatic t_stop_holdoff();
    mon_half = 0;
    arm(1'b0, 16'd200, 16'd8, 16'd12);
    wait_cyc(150);
    check("R2 hold-off masks stopped clock", {31'b0, fault}, 32'h0);
    wait_cyc(90);
    check("R7 stopped clock flagged", {31'b0, fault}, 32'h1);
    wr(1'b0, 32'h0);
  endtask

  task automatic t_sleep();
    mon_half = 5;
    arm(1'b0, 16'd100, 16'd8, 16'd12);
    wait_cyc(200);
    check("R8 running before sleep", {31'b0, fault}, 32'h0);
    mon_half = 0;
    wait_cyc(60);
    check("R7 loss before sleep", {31'b0, fault}, 32'h1);
    @(negedge clk); sleep = 1'b1;
    wait_cyc(2);
    check("R10 sleep clears fault", {31'b0, fault}, 32'h0);
    wait_cyc(40);
    check("R10 stays low in sleep", {31'b0, fault}, 32'h0);
    @(negedge clk); sleep = 1'b0;
    wait_cyc(60);
    check("R3 fresh hold-off after wake", {31'b0, fault}, 32'h0);
    wait_cyc(90);
    check("R3 supervision resumes after wake", {31'b0, fault}, 32'h1);
    wr(1'b0, 32'h0);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset();
    t_regs();
    t_window();
    t_fast();
    t_slow();
    t_stop_holdoff();
    t_sleep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule